// File: doc/BRIEF.md
# Indexed Register Port with Interrupt Flags

This block gives a host a two-address window onto a 128-byte space of control registers and general storage. A request whose select bit is 0 loads an index latch; a request whose select bit is 1 reads or writes the byte at the latched index. Four control bytes live at indices 10 to 13. Index 10 is the rate/status control, 11 the mode control, 12 the interrupt flag byte and 13 a constant status byte. All other indices behave as plain read/write storage. The counting and divider logic sits outside the block. It sees the two writable control bytes on output pins and feeds back flag-set pulses and update-busy pulses.

Host requests use a valid/ready channel. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Each read that is taken produces exactly one response beat on a valid/ready response channel. The response holds its data while `rsp_ready` is low. While a response is waiting, `req_ready` stays low, so at most one read is outstanding. Writes produce no response.

The flag byte collects events from three sources and drives a level interrupt. Reading the flag byte hands its contents to the host, empties it and drops the interrupt. An event that arrives in the same cycle as that read is kept.

Top module: `ixreg_port`

## Requirements
- R1: A taken write with select 0 stores the low 7 bits of the data as the index, and bit 7 is ignored. A taken read with select 0 returns 0xFF.
- R2: After reset, index 10 reads 0x26, index 11 reads 0x02, index 12 reads 0x00 and index 13 reads 0x80. `irq` is low, `rsp_valid` is low and `req_ready` is high.
- R3: Writes to index 12 and index 13 have no effect.
- R4: Bit 7 of index 10 (update busy) cannot be changed by a host write, which updates only bits 6:0. A `uip_set` pulse sets the bit and a `uip_clr` pulse clears it.
- R5: A write to index 11 with bit 7 (set mode) at 1 stores bit 4 (update-end enable) as 0 and clears bit 7 of index 10. With bit 7 at 0, the value is stored unchanged.
- R6: A read of index 12 returns its contents. After that read the byte is 0x00 and `irq` is low, unless a flag pulse arrived in the same cycle.
- R7: A `flag_periodic` pulse ORs 0xC0 into index 12, `flag_alarm` ORs 0xA0 and `flag_update` ORs 0x90. Any of them raises `irq` on the next edge.
- R8: A flag pulse in the same cycle as a read of index 12 is not lost. It stays in index 12 and keeps `irq` high.
- R9: `irq` is a level. It stays high until index 12 is read, whatever other accesses occur.
- R10: Indices 0 to 9 and 14 to 127 store and return any byte value.
- R11: `req_ready` is low exactly while a response is waiting with `rsp_ready` low. A waiting response keeps `rsp_valid` and `rsp_data` stable. A taken write produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 1 | 0 = index latch, 1 = data at index |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Host can take the response |
| rsp_data | output | 8 | Read response data |
| flag_periodic | input | 1 | Periodic event pulse |
| flag_alarm | input | 1 | Alarm event pulse |
| flag_update | input | 1 | Update-ended event pulse |
| uip_set | input | 1 | Set update-busy bit |
| uip_clr | input | 1 | Clear update-busy bit |
| ctrl_a | output | 8 | Current value at index 10 |
| ctrl_b | output | 8 | Current value at index 11 |
| irq | output | 1 | Level interrupt request |

## Verification
The properties assume several things about the inputs. Flag and update-busy inputs are single-cycle pulses. `uip_set` and `uip_clr` are never high together. Request fields do not change while a request is held waiting for `req_ready`. The stimulus drives every input on the falling edge, raises each pulse for one cycle only, and never raises both update-busy inputs in the same cycle. It lowers `rsp_ready` only in the back-pressure case, and holds the request unchanged while the response waits.

// File: rtl/ixp_pkg.sv
package ixp_pkg;

  localparam int DW = 8;

  // control byte positions inside the index space
  localparam int IX_RATE  = 10;
  localparam int IX_MODE  = 11;
  localparam int IX_FLAGS = 12;
  localparam int IX_STAT  = 13;

  localparam logic [DW-1:0] RATE_RST  = 8'h26;
  localparam logic [DW-1:0] MODE_RST  = 8'h02;
  localparam logic [DW-1:0] FLAGS_RST = 8'h00;
  localparam logic [DW-1:0] STAT_VAL  = 8'h80;
  localparam logic [DW-1:0] EVEN_READ = 8'hFF;

  localparam int BUSY_BIT  = 7;
  localparam int SETM_BIT  = 7;
  localparam int UEND_BIT  = 4;

  localparam int NSRC = 3;

  typedef enum logic [2:0] {
    K_STORE,
    K_RATE,
    K_MODE,
    K_FLAGS,
    K_STAT
  } kind_e;

  // OR pattern contributed by each event source
  function automatic logic [DW-1:0] src_code(input int i);
    case (i)
      0:       return 8'hC0;
      1:       return 8'hA0;
      default: return 8'h90;
    endcase
  endfunction

endpackage

// File: rtl/ixp_store.sv
module ixp_store #(
  parameter int IDX_W = 7,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/ixp_ctrl_regs.sv
module ixp_ctrl_regs
  import ixp_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_rate,
  input  logic          wr_mode,
  input  logic [DW-1:0] wdata,
  input  logic          uip_set,
  input  logic          uip_clr,
  output logic [DW-1:0] rate_q,
  output logic [DW-1:0] mode_q
);
  logic          busy_n;
  logic [DW-1:0] mode_n;
  logic [DW-1:0] rate_n;
  logic          entering_set;

  assign entering_set = wr_mode && wdata[SETM_BIT];

  always_comb begin
    if (entering_set)   busy_n = 1'b0;
    else if (uip_clr)   busy_n = 1'b0;
    else if (uip_set)   busy_n = 1'b1;
    else                busy_n = rate_q[BUSY_BIT];

    rate_n = rate_q;
    if (wr_rate) rate_n = wdata;
    rate_n[BUSY_BIT] = busy_n;

    mode_n = mode_q;
    if (wr_mode) begin
      mode_n = wdata;
      if (wdata[SETM_BIT]) mode_n[UEND_BIT] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate_q <= RATE_RST;
      mode_q <= MODE_RST;
    end else begin
      rate_q <= rate_n;
      mode_q <= mode_n;
    end
  end
endmodule

// File: rtl/ixp_flag_reg.sv
module ixp_flag_reg
  import ixp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_pulse,
  input  logic            rd_clear,
  output logic [DW-1:0]   flags_q,
  output logic            irq_q
);
  logic [DW-1:0] set_bits [NSRC+1];

  assign set_bits[0] = '0;

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_src
      assign set_bits[g+1] = set_bits[g] | (src_pulse[g] ? src_code(g) : '0);
    end
  endgenerate

  logic          any_set;
  logic [DW-1:0] flags_n;
  logic          irq_n;

  always_comb begin
    any_set = |src_pulse;
    flags_n = (rd_clear ? FLAGS_RST : flags_q) | set_bits[NSRC];
    if (any_set)       irq_n = 1'b1;
    else if (rd_clear) irq_n = 1'b0;
    else               irq_n = irq_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= FLAGS_RST;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= flags_n;
      irq_q   <= irq_n;
    end
  end
endmodule

// File: rtl/ixreg_port.sv
module ixreg_port
  import ixp_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic          req_sel,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data,
  input  logic          flag_periodic,
  input  logic          flag_alarm,
  input  logic          flag_update,
  input  logic          uip_set,
  input  logic          uip_clr,
  output logic [DW-1:0] ctrl_a,
  output logic [DW-1:0] ctrl_b,
  output logic          irq
);
  logic [IDX_W-1:0] idx_q;
  logic             take;
  logic             take_rd;
  logic             take_wr;
  kind_e            kind;
  logic [DW-1:0]    store_rd;
  logic [DW-1:0]    flags_q;
  logic [DW-1:0]    rd_mux;
  logic             rsp_valid_q;
  logic [DW-1:0]    rsp_data_q;

  assign req_ready = !rsp_valid_q || rsp_ready;
  assign take      = req_valid && req_ready;
  assign take_rd   = take && !req_write;
  assign take_wr   = take && req_write;

  // index latch
  always_ff @(posedge clk) begin
    if (!rst_n)                   idx_q <= '0;
    else if (take_wr && !req_sel) idx_q <= req_wdata[IDX_W-1:0];
  end

  // classify the latched index
  always_comb begin
    if      (idx_q == IDX_W'(IX_RATE))  kind = K_RATE;
    else if (idx_q == IDX_W'(IX_MODE))  kind = K_MODE;
    else if (idx_q == IDX_W'(IX_FLAGS)) kind = K_FLAGS;
    else if (idx_q == IDX_W'(IX_STAT))  kind = K_STAT;
    else                                kind = K_STORE;
  end

  ixp_store #(.IDX_W(IDX_W), .DW(DW)) u_store (
    .clk   (clk),
    .we    (take_wr && req_sel && kind == K_STORE),
    .addr  (idx_q),
    .wdata (req_wdata),
    .rdata (store_rd)
  );

  ixp_ctrl_regs u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_rate (take_wr && req_sel && kind == K_RATE),
    .wr_mode (take_wr && req_sel && kind == K_MODE),
    .wdata   (req_wdata),
    .uip_set (uip_set),
    .uip_clr (uip_clr),
    .rate_q  (ctrl_a),
    .mode_q  (ctrl_b)
  );

  ixp_flag_reg u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_pulse ({flag_update, flag_alarm, flag_periodic}),
    .rd_clear  (take_rd && req_sel && kind == K_FLAGS),
    .flags_q   (flags_q),
    .irq_q     (irq)
  );

  always_comb begin
    if (!req_sel) rd_mux = EVEN_READ;
    else begin
      case (kind)
        K_RATE:  rd_mux = ctrl_a;
        K_MODE:  rd_mux = ctrl_b;
        K_FLAGS: rd_mux = flags_q;
        K_STAT:  rd_mux = STAT_VAL;
        default: rd_mux = store_rd;
      endcase
    end
  end

  // response channel
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else if (take_rd) begin
      rsp_valid_q <= 1'b1;
      rsp_data_q  <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
endmodule

// File: rtl/ixreg_port_chk.sv
module ixreg_port_chk #(
  parameter int IDX_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_write,
  input logic             req_sel,
  input logic [7:0]       req_wdata,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [7:0]       rsp_data,
  input logic             flag_periodic,
  input logic             flag_alarm,
  input logic             flag_update,
  input logic             uip_set,
  input logic             uip_clr,
  input logic [7:0]       ctrl_a,
  input logic [7:0]       ctrl_b,
  input logic             irq,
  input logic [IDX_W-1:0] idx
);
  logic acc, any_flag, rd_flags, wr_rate, wr_mode;
  assign acc      = req_valid && req_ready;
  assign any_flag = flag_periodic || flag_alarm || flag_update;
  assign rd_flags = acc && !req_write && req_sel && idx == IDX_W'(12);
  assign wr_rate  = acc && req_write && req_sel && idx == IDX_W'(10);
  assign wr_mode  = acc && req_write && req_sel && idx == IDX_W'(11);

  AST_EVEN_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !req_write && !req_sel |=> rsp_valid && rsp_data == 8'hFF); // R1
  AST_UIP_HOST_RO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rate && !uip_set && !uip_clr |=> ctrl_a[7] == $past(ctrl_a[7])); // R4
  AST_SET_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mode && req_wdata[7] |=> !ctrl_b[4] && !ctrl_a[7]); // R5
  AST_READ_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_flags && !any_flag |=> !irq); // R6
  AST_FLAG_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    any_flag |=> irq); // R7
  AST_FLAG_KEPT_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_flags && any_flag |=> irq); // R8
  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !rd_flags |=> irq); // R9
  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data)); // R11
  AST_WRITE_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_write |=> !rsp_valid); // R11
endmodule

bind ixreg_port ixreg_port_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_sel(req_sel), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
  .flag_periodic(flag_periodic), .flag_alarm(flag_alarm),
  .flag_update(flag_update), .uip_set(uip_set), .uip_clr(uip_clr),
  .ctrl_a(ctrl_a), .ctrl_b(ctrl_b), .irq(irq), .idx(idx_q)
);

// File: tb/test_ixreg_port.sv
module test_ixreg_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_write = 1'b0, req_sel = 1'b0;
  logic [7:0] req_wdata = '0;
  logic       rsp_ready = 1'b1;
  logic       flag_periodic = 1'b0, flag_alarm = 1'b0, flag_update = 1'b0;
  logic       uip_set = 1'b0, uip_clr = 1'b0;
  logic       req_ready, rsp_valid, irq;
  logic [7:0] rsp_data, ctrl_a, ctrl_b;

  int errors = 0;
  int checks = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  ixreg_port i_ixreg_port (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_sel(req_sel), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .flag_periodic(flag_periodic), .flag_alarm(flag_alarm),
    .flag_update(flag_update), .uip_set(uip_set), .uip_clr(uip_clr),
    .ctrl_a(ctrl_a), .ctrl_b(ctrl_b), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_sel = sel; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_sel = sel;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_valid ? rsp_data : 8'hXX;
  endtask

  task automatic rd_at(input int ix, output logic [7:0] d);
    wr(1'b0, 8'(ix));
    rd(1'b1, d);
  endtask

  task automatic pulse(input logic p, input logic a, input logic u);
    @(negedge clk);
    flag_periodic = p; flag_alarm = a; flag_update = u;
    @(negedge clk);
    flag_periodic = 1'b0; flag_alarm = 1'b0; flag_update = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
    end
  end

  initial begin
    logic [7:0] d, e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reset state
    check("R2 irq", {7'd0, irq}, 8'h00);
    check("R2 rsp_valid", {7'd0, rsp_valid}, 8'h00);
    check("R2 req_ready", {7'd0, req_ready}, 8'h01);
    check("R2 ctrl_a", ctrl_a, 8'h26);
    check("R2 ctrl_b", ctrl_b, 8'h02);
    rd_at(10, d); check("R2 idx10", d, 8'h26);
    rd_at(11, d); check("R2 idx11", d, 8'h02);
    rd_at(12, d); check("R2 idx12", d, 8'h00);
    rd_at(13, d); check("R2 idx13", d, 8'h80);

    // R1 even read, index bit 7 ignored
    rd(1'b0, d); check("R1 even read", d, 8'hFF);
    wr(1'b0, 8'h8B); rd(1'b1, d); check("R1 index low bits", d, 8'h02);

    // R10 storage sweep
    for (int i = 0; i < 128; i++) begin
      if (i < 10 || i > 13) begin
        wr(1'b0, 8'(i)); wr(1'b1, 8'((i * 37 + 5) & 8'hFF));
      end
    end
    for (int i = 0; i < 128; i++) begin
      if (i < 10 || i > 13) begin
        rd_at(i, d); check("R10 storage", d, 8'((i * 37 + 5) & 8'hFF));
      end
    end
    wr(1'b0, 8'd14); wr(1'b1, 8'hFF); wr(1'b1, 8'h00);
    rd(1'b1, d); check("R10 overwrite", d, 8'h00);

    // R3 read-only bytes
    wr(1'b0, 8'd12); wr(1'b1, 8'hFF); rd(1'b1, d); check("R3 idx12", d, 8'h00);
    check("R3 irq", {7'd0, irq}, 8'h00);
    wr(1'b0, 8'd13); wr(1'b1, 8'h00); rd(1'b1, d); check("R3 idx13", d, 8'h80);

    // R4 busy bit read-only to host
    wr(1'b0, 8'd10);
    for (int v = 0; v < 256; v += 17) begin
      wr(1'b1, 8'(v)); rd(1'b1, d); check("R4 rate write", d, {1'b0, 7'(v)});
    end
    @(negedge clk); uip_set = 1'b1; @(negedge clk); uip_set = 1'b0;
    check("R4 uip_set", ctrl_a[7] ? 8'h01 : 8'h00, 8'h01);
    wr(1'b1, 8'h26); rd(1'b1, d); check("R4 busy kept", d, 8'hA6);
    @(negedge clk); uip_clr = 1'b1; @(negedge clk); uip_clr = 1'b0;
    check("R4 uip_clr", ctrl_a, 8'h26);

    // R5 mode writes, near-exhaustive
    wr(1'b0, 8'd11);
    for (int v = 0; v < 256; v += 3) begin
      @(negedge clk); uip_set = 1'b1; @(negedge clk); uip_set = 1'b0;
      wr(1'b1, 8'(v));
      e = v[7] ? (8'(v) & 8'hEF) : 8'(v);
      check("R5 mode value", ctrl_b, e);
      check("R5 busy", {7'd0, ctrl_a[7]}, v[7] ? 8'h00 : 8'h01);
    end
    @(negedge clk); uip_clr = 1'b1; @(negedge clk); uip_clr = 1'b0;
    wr(1'b1, 8'h02);

    // R7 / R6 all flag combinations
    wr(1'b0, 8'd12);
    for (int m = 1; m < 8; m++) begin
      pulse(m[0], m[1], m[2]);
      check("R7 irq", {7'd0, irq}, 8'h01);
      e = (m[0] ? 8'hC0 : 8'h00) | (m[1] ? 8'hA0 : 8'h00) | (m[2] ? 8'h90 : 8'h00);
      rd(1'b1, d); check("R7 flag code", d, e);
      check("R6 irq dropped", {7'd0, irq}, 8'h00);
      rd(1'b1, d); check("R6 cleared", d, 8'h00);
    end

    // R9 level held across other accesses
    pulse(1'b0, 1'b0, 1'b1);
    repeat (20) @(negedge clk);
    check("R9 hold", {7'd0, irq}, 8'h01);
    rd_at(11, d); rd_at(40, d); rd(1'b0, d);
    check("R9 other reads", {7'd0, irq}, 8'h01);
    wr(1'b0, 8'd12); rd(1'b1, d); check("R9 flags", d, 8'h90);
    check("R9 dropped", {7'd0, irq}, 8'h00);

    // R8 flag arriving with the read
    pulse(1'b1, 1'b0, 1'b0);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_sel = 1'b1; flag_alarm = 1'b1;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0; flag_alarm = 1'b0;
    check("R8 read value", rsp_data, 8'hC0);
    check("R8 irq kept", {7'd0, irq}, 8'h01);
    rd(1'b1, d); check("R8 flag kept", d, 8'hA0);
    check("R8 irq after", {7'd0, irq}, 8'h00);

    // R11 back-pressure
    wr(1'b0, 8'd13);
    @(negedge clk); rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_sel = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R11 waiting valid", {7'd0, rsp_valid}, 8'h01);
    check("R11 ready low", {7'd0, req_ready}, 8'h00);
    repeat (3) @(negedge clk);
    check("R11 data held", rsp_data, 8'h80);
    check("R11 still valid", {7'd0, rsp_valid}, 8'h01);
    req_valid = 1'b0; rsp_ready = 1'b1;
    @(negedge clk);
    check("R11 popped", {7'd0, rsp_valid}, 8'h00);
    wr(1'b0, 8'd20);
    check("R11 write no rsp", {7'd0, rsp_valid}, 8'h00);

    done = 1'b1;
    summary();
  end
endmodule